// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked request bus and an external 256K x 8 asynchronous static RAM. A requester presents a single-beat read or write with a valid/ready handshake. The controller turns it into the address, the two chip selects of opposite polarity, and the output-enable and write-enable strobes the RAM needs. It holds each strobe for a whole number of core clock cycles. That number is derived from nanosecond timing parameters and the core clock frequency, rounded up. Read data is captured at the end of the access window and returned with a one-cycle response pulse.

The shared data bus is split at the block's edge into an output value, a drive enable for the pad and an input value. The controller turns on its drive enable only for a write. It never does so while the RAM may still be driving the bus after a read. A standby input parks the RAM in its low-power retention state with both chip selects inactive. When standby is released, the controller waits one full read-cycle time before it accepts the next request.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, mem_sel_lo_n=1, mem_outen_n=1, mem_wren_n=1, mem_data_drv=0, rsp_valid=0 and req_ready=1 (with standby_req low).
- R2: A read holds mem_sel_lo_n=0, mem_sel_hi=1, mem_wren_n=1 and mem_outen_n=0 for RD_CYC = ceil(max(read cycle, access time) x f) cycles (6 at 100 MHz, 3 at 50 MHz). It then raises rsp_valid for exactly one cycle, with rsp_rdata equal to the bus value at the end of that window. Responses return in request order.
- R3: A write presents the accepted address on mem_addr and drives the write data with mem_data_drv=1. It holds mem_wren_n=0 for WP_CYC = ceil(max(write pulse, address-to-end, select-to-end, data setup) x f) cycles (5 at 100 MHz, 3 at 50 MHz), with both chip selects active throughout.
- R4: The active chip-select period of a write lasts WP_CYC + REC_CYC cycles. REC_CYC is the larger of 1 and ceil(write cycle x f) - WP_CYC. A read's active period lasts RD_CYC cycles. mem_addr stays constant while mem_sel_lo_n is low.
- R5: mem_data_drv is never 1 while mem_outen_n=0. After mem_outen_n rises, mem_data_drv stays 0 for at least HZ_CYC = max(1, ceil(output release time x f)) cycles.
- R6: req_ready is 0 from the cycle after a request is accepted until the access and its recovery are complete. A held request is accepted once, later.
- R7: With no access in progress and no standby, mem_sel_lo_n=1, mem_outen_n=1, mem_wren_n=1 and mem_data_drv=0.
- R8: While standby_req is high and the controller has entered standby, mem_sel_lo_n=1, mem_sel_hi=0 and req_ready=0. Requests presented then start no strobe and leave the RAM contents unchanged.
- R9: After standby_req falls, req_ready stays 0 for WAKE_CYC = ceil(read cycle x f) cycles (6 at 100 MHz, 3 at 50 MHz).
- R10: mem_outen_n and mem_wren_n are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W | Captured read data |
| standby_req | input | 1 | Enter low-power retention while high |
| mem_addr | output | ADDR_W | RAM address |
| mem_sel_lo_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_outen_n | output | 1 | Active-low RAM output enable |
| mem_wren_n | output | 1 | Active-low RAM write enable |
| mem_data_out | output | DATA_W | Value for the data pads |
| mem_data_drv | output | 1 | Pad drive enable for the data bus |
| mem_data_in | input | DATA_W | Value seen on the data pads |

## Verification
The properties assume the requester raises standby_req only while it has no request in flight. The bench waits for an idle controller before it does so. They also assume the RAM releases the bus within the configured release time, which the bench RAM model meets by driving the bus only while it is selected for a read. The bench holds req_valid through busy periods and during standby to exercise the hold-off. It drops the request before it leaves standby, so the controller accepts no stray write.

// File: rtl/sram_ctl_pkg.sv
// Shared types and timing helpers for the asynchronous SRAM controller.
// Assumes timing parameters in whole nanoseconds and clock in MHz.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WREC,
        ST_SLEEP,
        ST_WAKE
    } ctl_state_t;

    typedef struct packed {
        logic sel_lo_n;
        logic sel_hi;
        logic outen_n;
        logic wren_n;
        logic drv;
    } strobe_t;

    // Nanoseconds to clock cycles, rounded up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Down counter that times each controller phase.
// A load of N-1 makes the phase last N cycles; done is high when the count is zero.
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
// Sequencer for the SRAM controller: accepts requests, steps through the
// access, recovery, turnaround and standby phases, and registers the strobes.
// Assumes every *_CYC parameter is at least 1 and fits in CNT_W bits.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 6,
    parameter int unsigned WP_CYC   = 5,
    parameter int unsigned REC_CYC  = 1,
    parameter int unsigned HZ_CYC   = 2,
    parameter int unsigned WAKE_CYC = 6,
    parameter int unsigned CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             standby_req,
    input  logic             timer_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output strobe_t          strobes
);
    ctl_state_t state, state_nx;

    // Strobe levels for each phase; the idle values deselect the RAM.
    function automatic strobe_t decode(input ctl_state_t s);
        strobe_t o;
        o = '{sel_lo_n: 1'b1, sel_hi: 1'b1, outen_n: 1'b1, wren_n: 1'b1, drv: 1'b0};
        case (s)
            ST_READ:  begin o.sel_lo_n = 1'b0; o.outen_n = 1'b0; end
            ST_WRITE: begin o.sel_lo_n = 1'b0; o.wren_n = 1'b0; o.drv = 1'b1; end
            ST_WREC:  begin o.sel_lo_n = 1'b0; o.drv = 1'b1; end
            ST_SLEEP: o.sel_hi = 1'b0;
            default:  ;
        endcase
        return o;
    endfunction

    // Handshake: only an idle controller outside standby takes a request.
    always_comb begin
        req_ready = (state == ST_IDLE) && !standby_req;
        accept    = req_ready && req_valid;
    end

    // Next phase, timer reload and read capture.
    always_comb begin
        state_nx   = state;
        timer_load = 1'b0;
        timer_val  = '0;
        capture    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (standby_req) begin
                    state_nx = ST_SLEEP;
                end else if (req_valid) begin
                    timer_load = 1'b1;
                    if (req_write) begin
                        state_nx  = ST_WRITE;
                        timer_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        state_nx  = ST_READ;
                        timer_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: if (timer_done) begin
                capture    = 1'b1;
                state_nx   = ST_TURN;
                timer_load = 1'b1;
                timer_val  = CNT_W'(HZ_CYC - 1);
            end
            ST_TURN:  if (timer_done) state_nx = ST_IDLE;
            ST_WRITE: if (timer_done) begin
                state_nx   = ST_WREC;
                timer_load = 1'b1;
                timer_val  = CNT_W'(REC_CYC - 1);
            end
            ST_WREC:  if (timer_done) state_nx = ST_IDLE;
            ST_SLEEP: if (!standby_req) begin
                state_nx   = ST_WAKE;
                timer_load = 1'b1;
                timer_val  = CNT_W'(WAKE_CYC - 1);
            end
            ST_WAKE:  if (timer_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Phase register and glitch-free registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            strobes <= decode(ST_IDLE);
        end else begin
            state   <= state_nx;
            strobes <= decode(state_nx);
        end
    end
endmodule

// File: rtl/sram_ctl_datapath.sv
// Address, write-data and read-data registers of the SRAM controller.
// Assumes accept and capture are never high in the same cycle.
module sram_ctl_datapath #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_data_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Hold address and write data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr     <= '0;
            mem_data_out <= '0;
        end else if (accept) begin
            mem_addr     <= req_addr;
            mem_data_out <= req_wdata;
        end
    end

    // Sample the bus at the end of the access window and pulse the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= mem_data_in;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
// Top of the asynchronous SRAM controller. Converts valid/ready requests into
// timed strobes for a dual-select 8-bit static RAM, with standby retention.
// Assumes CLK_MHZ and the *_NS timings describe the RAM grade in use.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned T_RC_NS  = 55,
    parameter int unsigned T_AA_NS  = 55,
    parameter int unsigned T_WC_NS  = 55,
    parameter int unsigned T_WP_NS  = 40,
    parameter int unsigned T_AW_NS  = 45,
    parameter int unsigned T_CW_NS  = 45,
    parameter int unsigned T_DW_NS  = 25,
    parameter int unsigned T_HZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              standby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_lo_n,
    output logic              mem_sel_hi,
    output logic              mem_outen_n,
    output logic              mem_wren_n,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              mem_data_drv,
    input  logic [DATA_W-1:0] mem_data_in
);
    localparam int unsigned RD_CYC   = max2(1, ns_to_cyc(max2(T_RC_NS, T_AA_NS), CLK_MHZ));
    localparam int unsigned WP_CYC   = max2(1, ns_to_cyc(max2(max2(T_WP_NS, T_AW_NS),
                                                             max2(T_CW_NS, T_DW_NS)), CLK_MHZ));
    localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_MHZ);
    localparam int unsigned REC_CYC  = (WC_CYC > WP_CYC + 1) ? WC_CYC - WP_CYC : 1;
    localparam int unsigned HZ_CYC   = max2(1, ns_to_cyc(T_HZ_NS, CLK_MHZ));
    localparam int unsigned WAKE_CYC = max2(1, ns_to_cyc(T_RC_NS, CLK_MHZ));
    localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC),
                                            max2(max2(REC_CYC, HZ_CYC), WAKE_CYC));
    localparam int unsigned CNT_W    = max2(1, $clog2(MAX_CYC + 1));

    logic             accept, capture, timer_load, timer_done;
    logic [CNT_W-1:0] timer_val;
    strobe_t          strobes;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .done(timer_done)
    );

    sram_ctl_fsm #(
        .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC),
        .HZ_CYC(HZ_CYC), .WAKE_CYC(WAKE_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .standby_req(standby_req), .timer_done(timer_done), .req_ready(req_ready),
        .accept(accept), .capture(capture), .timer_load(timer_load),
        .timer_val(timer_val), .strobes(strobes)
    );

    sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture(capture), .mem_data_in(mem_data_in),
        .mem_addr(mem_addr), .mem_data_out(mem_data_out),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign mem_sel_lo_n = strobes.sel_lo_n;
    assign mem_sel_hi   = strobes.sel_hi;
    assign mem_outen_n  = strobes.outen_n;
    assign mem_wren_n   = strobes.wren_n;
    assign mem_data_drv = strobes.drv;
endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for sram_ctl, bound to every instance.
// Assumes standby is only requested while the controller is idle.
module sram_ctl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned HZ_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_lo_n,
    input logic              mem_sel_hi,
    input logic              mem_outen_n,
    input logic              mem_wren_n,
    input logic              mem_data_drv
);
    localparam int unsigned SW = $clog2(HZ_CYC + 1) + 1;
    logic [SW-1:0] since_oe;

    // Cycles since the output enable was last active, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_oe <= SW'(HZ_CYC);
        else if (!mem_outen_n)              since_oe <= '0;
        else if (since_oe < SW'(HZ_CYC))    since_oe <= since_oe + 1'b1;
    end

    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_drv |-> mem_outen_n);
    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_drv |-> (since_oe >= SW'(HZ_CYC)));
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wren_n |-> mem_outen_n);
    a_r3_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wren_n |-> (!mem_sel_lo_n && mem_sel_hi && mem_data_drv));
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_lo_n && $past(!mem_sel_lo_n)) |-> $stable(mem_addr));
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r8_sleep_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_hi |-> (mem_sel_lo_n && !req_ready && mem_wren_n));
    a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .HZ_CYC(HZ_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_sel_lo_n(mem_sel_lo_n),
    .mem_sel_hi(mem_sel_hi), .mem_outen_n(mem_outen_n), .mem_wren_n(mem_wren_n),
    .mem_data_drv(mem_data_drv)
);

// File: tb/sram_ctl_test.sv
// Scoreboard bench for sram_ctl with a behavioural RAM on the pad side.
module sram_ctl_test;
    localparam int MHZ    = 50;
    localparam int E_RD   = (55 * MHZ + 999) / 1000;
    localparam int E_WP   = (45 * MHZ + 999) / 1000;
    localparam int E_WC   = (55 * MHZ + 999) / 1000;
    localparam int E_REC  = (E_WC > E_WP + 1) ? E_WC - E_WP : 1;
    localparam int E_HZ   = ((20 * MHZ + 999) / 1000 > 1) ? (20 * MHZ + 999) / 1000 : 1;
    localparam int E_WAKE = E_RD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_sel_lo_n, mem_sel_hi, mem_outen_n, mem_wren_n, mem_data_drv;
    logic [7:0]  mem_data_out, mem_data_in;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sram_ctl #(.CLK_MHZ(MHZ)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .standby_req(standby_req),
        .mem_addr(mem_addr), .mem_sel_lo_n(mem_sel_lo_n), .mem_sel_hi(mem_sel_hi),
        .mem_outen_n(mem_outen_n), .mem_wren_n(mem_wren_n), .mem_data_out(mem_data_out),
        .mem_data_drv(mem_data_drv), .mem_data_in(mem_data_in)
    );

    // RAM model: stores on the rising write enable, drives only when read-selected.
    logic [7:0] ram [0:1023];
    logic [7:0] shadow [0:1023];
    initial for (int i = 0; i < 1024; i++) begin ram[i] = 8'(i * 7 + 3); shadow[i] = 8'(i * 7 + 3); end
    always @(posedge mem_wren_n)
        if (rst_n && !mem_sel_lo_n && mem_sel_hi && mem_data_drv) ram[mem_addr[9:0]] = mem_data_out;
    always_comb
        mem_data_in = (!mem_sel_lo_n && mem_sel_hi && !mem_outen_n && mem_wren_n)
                      ? ram[mem_addr[9:0]] : 8'hEE;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard queue of expected read data, in request order.
    logic [7:0] expq [$];

    // Driver: present a request at a falling edge and hold it until accepted.
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) shadow[a[9:0]] = d; else expq.push_back(shadow[a[9:0]]);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_addr == a, wr ? "R3 address" : "R2 address", int'(mem_addr), int'(a));
    endtask

    // Monitor: run lengths, contention and response comparison.
    int we_run = 0, oe_run = 0, cs_run = 0, since_oe = 100;
    bit had_we = 0, bad_r5 = 0, bad_r10 = 0, bad_r6 = 0, bad_r4 = 0;
    logic [17:0] run_addr;
    always @(negedge clk) if (rst_n) begin
        if (rsp_valid) begin
            if (expq.size() == 0) check(0, "R2 unexpected response", int'(rsp_rdata), 0);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(rsp_rdata == e, "R2 read data", int'(rsp_rdata), int'(e));
            end
        end
        if (!mem_wren_n) we_run++;
        else if (we_run != 0) begin check(we_run == E_WP, "R3 write pulse", we_run, E_WP); we_run = 0; end
        if (!mem_outen_n) oe_run++;
        else if (oe_run != 0) begin check(oe_run == E_RD, "R2 read window", oe_run, E_RD); oe_run = 0; end
        if (!mem_sel_lo_n) begin
            if (cs_run == 0) run_addr = mem_addr;
            else if (mem_addr != run_addr) bad_r4 = 1;
            cs_run++;
            if (!mem_wren_n) had_we = 1;
            if (req_ready) bad_r6 = 1;
        end else if (cs_run != 0) begin
            check(cs_run == (had_we ? E_WP + E_REC : E_RD), "R4 select period",
                  cs_run, had_we ? E_WP + E_REC : E_RD);
            cs_run = 0; had_we = 0;
        end
        if (!mem_outen_n) since_oe = 0; else if (since_oe < 100) since_oe++;
        if (mem_data_drv && (!mem_outen_n || since_oe <= E_HZ)) bad_r5 = 1;
        if (!mem_outen_n && !mem_wren_n) bad_r10 = 1;
    end

    task automatic wait_idle();
        while (!req_ready || expq.size() != 0) @(negedge clk);
    endtask

    initial begin
        int n;
        bit bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_sel_lo_n && mem_outen_n && mem_wren_n && !mem_data_drv && !rsp_valid && req_ready,
              "R1 reset state", {mem_sel_lo_n, mem_outen_n, mem_wren_n, mem_data_drv, rsp_valid, req_ready},
              6'b111001);
        rst_n = 1'b1;
        // R3/R2: writes of several patterns, then read back
        do_req(1, 18'h00000, 8'h00);
        do_req(1, 18'h00001, 8'hFF);
        do_req(1, 18'h002AA, 8'hA5);
        do_req(1, 18'h3FFFE, 8'h5A);
        do_req(0, 18'h00000, 8'h00);
        do_req(0, 18'h00001, 8'h00);
        do_req(0, 18'h002AA, 8'h00);
        do_req(0, 18'h3FFFE, 8'h00);
        // R2: unwritten location returns RAM content
        do_req(0, 18'h00123, 8'h00);
        // R5/R6: read immediately followed by write and read
        do_req(0, 18'h00001, 8'h00);
        do_req(1, 18'h00002, 8'h3C);
        do_req(0, 18'h00002, 8'h00);
        wait_idle();
        repeat (3) @(negedge clk);
        // R7 idle deselect
        check(mem_sel_lo_n && mem_outen_n && mem_wren_n && !mem_data_drv, "R7 idle strobes",
              {mem_sel_lo_n, mem_outen_n, mem_wren_n, mem_data_drv}, 4'b1110);
        // R8 standby entry and ignored requests
        standby_req = 1'b1;
        @(negedge clk);
        check(mem_sel_lo_n && !mem_sel_hi && !req_ready, "R8 standby selects",
              {mem_sel_lo_n, mem_sel_hi, req_ready}, 3'b100);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00001; req_wdata = 8'h77;
        bad = 0;
        repeat (6) begin
            @(negedge clk);
            if (req_ready || !mem_wren_n || !mem_sel_lo_n || mem_sel_hi) bad = 1;
        end
        check(!bad, "R8 requests ignored in standby", bad, 0);
        req_valid = 1'b0;
        @(negedge clk);
        // R9 wake recovery
        standby_req = 1'b0;
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); if (!req_ready) n++; end
        if (!req_ready) n = 0;
        check(n == E_WAKE, "R9 wake cycles", n, E_WAKE);
        // R8: contents unchanged by the ignored write
        do_req(0, 18'h00001, 8'h00);
        wait_idle();
        repeat (4) @(negedge clk);
        check(!bad_r5, "R5 bus turnaround", bad_r5, 0);
        check(!bad_r10, "R10 strobe exclusion", bad_r10, 0);
        check(!bad_r6, "R6 ready low while busy", bad_r6, 0);
        check(!bad_r4, "R4 address stable", bad_r4, 0);
        check(expq.size() == 0, "R2 responses outstanding", expq.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule